// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block fills a translation-cache miss by walking a radix page table of a configurable number of levels held in memory. On a start strobe it captures the missing virtual page number and the base frame of the top-level table. It then reads one table entry per level through a simple request/grant/response read port. Each entry that is not on the last level points at the table one level down. The entry on the last level gives the physical frame and its permission bits, which the block hands back for installation in the translation cache. The page offset is never seen here because it passes through translation unchanged.

The virtual page number is cut into one index field per level. The most significant field selects the entry in the top-level table, and the least significant field selects the entry in the last-level table. As soon as an entry reports that it is not present, the walk stops with a fault pulse that names the level. Only one walk is in flight at a time, and `busy_o` is high while it runs.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy_o`, `mem_req_o`, `done_o` and `fault_o` are all low.
- R2: The first read of a walk goes to address `ptbr_i * 2^PG_SH + idx1 * PTE_BYTES`, where idx1 is the top IDX_W bits of the captured page number and `ptbr_i` is the table base frame sampled with the start strobe.
- R3: The read for level L > 1 goes to `frame(L-1) * 2^PG_SH + idxL * PTE_BYTES`. Here frame(L-1) is the frame field of the entry returned for level L-1, and idxL is the L-th IDX_W-bit field counted from the most significant end.
- R4: A request stays asserted with an unchanged address until `mem_gnt_i` is seen with it. After that no new request is raised until `mem_rvalid_i` returns the entry, however many cycles that takes.
- R5: A table entry is `PPN_W+PERM_W+1` bits: bit 0 is present, bits [PERM_W:1] are permissions, and the bits above them are the frame number.
- R6: A walk in which every entry is present makes exactly LEVELS reads. It ends with `done_o` high, with `res_ppn_o` and `res_perm_o` taken from the last-level entry.
- R7: An entry with present = 0 at level index L (0 = top) ends the walk at once. `fault_o` goes high, `fault_lvl_o` = L, and no further read is made.
- R8: `done_o` and `fault_o` are one-cycle pulses, never both high together. They appear in the cycle after the response is accepted, and `busy_o` is low in that cycle.
- R9: A start strobe while `busy_o` is high is ignored. The walk in progress keeps its captured page number and base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vpn_i | input | LEVELS*IDX_W | Missing virtual page number |
| ptbr_i | input | PPN_W | Frame of the top-level table |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | PPN_W+PG_SH | Byte address of the entry |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | PPN_W+PERM_W+1 | Returned table entry |
| done_o | output | 1 | Translation ready pulse |
| fault_o | output | 1 | Page fault pulse |
| fault_lvl_o | output | max(1,clog2(LEVELS)) | Level index where the fault was found |
| res_ppn_o | output | PPN_W | Translated frame number |
| res_perm_o | output | PERM_W | Permission bits of the translation |

## Verification
The bench answers every read from its own plan of entries, and it checks the address of every level against the base it handed out one level before. A walker that picked the index fields in the wrong order, or used the wrong frame as the next base, would miss at R2 or R3. Grant and response delays are random, so a walker that dropped its request, moved its address or issued an extra read while waiting would be caught. Faults are forced at the top and the last level. A walker that carried on after a non-present entry, or that reported the wrong level, shows extra reads or a wrong `fault_lvl_o`. Start strobes with other inputs are pushed in mid-walk, and the inputs are changed after capture, which exposes a walker that resamples them.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_state_e;
endpackage

// File: rtl/ptw_field_sel.sv
module ptw_field_sel #(
    parameter int LEVELS = 3,
    parameter int IDX_W  = 4,
    parameter int LVL_W  = 2
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    output logic [IDX_W-1:0]        idx
);
    localparam int VPN_W = LEVELS * IDX_W;

    logic [IDX_W-1:0] fields [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign fields[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (level == LVL_W'(k)) idx = fields[k];
        end
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PPN_W     = 8,
    parameter int PG_SH     = 12,
    parameter int IDX_W     = 4,
    parameter int PTE_BYTES = 4
) (
    input  logic [PPN_W-1:0]       base,
    input  logic [IDX_W-1:0]       idx,
    output logic [PPN_W+PG_SH-1:0] addr
);
    localparam int PA_W = PPN_W + PG_SH;

    assign addr = {base, {PG_SH{1'b0}}} + PA_W'(idx) * PA_W'(PTE_BYTES);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int PPN_W  = 8,
    parameter int PERM_W = 3
) (
    input  logic [PPN_W+PERM_W:0] pte,
    output logic                  present,
    output logic [PERM_W-1:0]     perm,
    output logic [PPN_W-1:0]      frame
);
    assign present = pte[0];
    assign perm    = pte[PERM_W:1];
    assign frame   = pte[PPN_W+PERM_W:PERM_W+1];
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS    = 3,
    parameter int IDX_W     = 4,
    parameter int PPN_W     = 8,
    parameter int PG_SH     = 12,
    parameter int PERM_W    = 3,
    parameter int PTE_BYTES = 4,
    localparam int VPN_W    = LEVELS * IDX_W,
    localparam int PA_W     = PPN_W + PG_SH,
    localparam int PTE_W    = PPN_W + PERM_W + 1,
    localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [PPN_W-1:0]  ptbr_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic [PA_W-1:0]   mem_addr_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [PTE_W-1:0]  mem_rdata_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [LVL_W-1:0]  fault_lvl_o,
    output logic [PPN_W-1:0]  res_ppn_o,
    output logic [PERM_W-1:0] res_perm_o
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);
    localparam int CNT_W = $clog2(LEVELS + 1);

    typedef struct packed {
        walk_state_e       st;
        logic [LVL_W-1:0]  level;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  base;
        logic              done;
        logic              fault;
        logic [LVL_W-1:0]  flvl;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    logic [IDX_W-1:0]  cur_idx;
    logic              pte_present;
    logic [PERM_W-1:0] pte_perm;
    logic [PPN_W-1:0]  pte_frame;
    logic              start_ok;

    ptw_field_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .LVL_W(LVL_W)) i_field_sel (
        .vpn   (r_q.vpn),
        .level (r_q.level),
        .idx   (cur_idx)
    );

    ptw_addr_gen #(.PPN_W(PPN_W), .PG_SH(PG_SH), .IDX_W(IDX_W), .PTE_BYTES(PTE_BYTES)) i_addr_gen (
        .base (r_q.base),
        .idx  (cur_idx),
        .addr (mem_addr_o)
    );

    ptw_pte_decode #(.PPN_W(PPN_W), .PERM_W(PERM_W)) i_pte_decode (
        .pte     (mem_rdata_i),
        .present (pte_present),
        .perm    (pte_perm),
        .frame   (pte_frame)
    );

    assign start_ok = (r_q.st == ST_IDLE) && start_i;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_REQ;
                    r_d.level = '0;
                    r_d.vpn   = vpn_i;
                    r_d.base  = ptbr_i;
                end
            end
            ST_REQ: begin
                if (mem_gnt_i) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    if (!pte_present) begin
                        r_d.st    = ST_IDLE;
                        r_d.fault = 1'b1;
                        r_d.flvl  = r_q.level;
                    end else if (r_q.level == LAST_LVL) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.ppn  = pte_frame;
                        r_d.perm = pte_perm;
                    end else begin
                        r_d.st    = ST_REQ;
                        r_d.base  = pte_frame;
                        r_d.level = r_q.level + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign mem_req_o   = (r_q.st == ST_REQ);
    assign done_o      = r_q.done;
    assign fault_o     = r_q.fault;
    assign fault_lvl_o = r_q.flvl;
    assign res_ppn_o   = r_q.ppn;
    assign res_perm_o  = r_q.perm;

    // Reads accepted since the last accepted start (checking aid only).
    logic [CNT_W-1:0] rd_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      rd_cnt_q <= '0;
        else if (start_ok)               rd_cnt_q <= '0;
        else if (mem_req_o && mem_gnt_i) rd_cnt_q <= rd_cnt_q + 1'b1;
    end

    a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r4_no_req_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_gnt_i) |=> !mem_req_o);

    a_r2_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ((mem_addr_o % PA_W'(PTE_BYTES)) == '0));

    a_r6_read_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rd_cnt_q == CNT_W'(LEVELS)));

    a_r7_fault_reads: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (rd_cnt_q == CNT_W'(fault_lvl_o) + 1'b1));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fault_o));

    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fault_o) |=> !(done_o || fault_o));

    a_r8_idle_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fault_o) |-> !busy_o);

    a_r9_keep_vpn: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(r_q.vpn));
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int LEVELS    = 3;
    localparam int IDX_W     = 4;
    localparam int PPN_W     = 8;
    localparam int PG_SH     = 12;
    localparam int PERM_W    = 3;
    localparam int PTE_BYTES = 4;
    localparam int VPN_W     = LEVELS * IDX_W;
    localparam int PA_W      = PPN_W + PG_SH;
    localparam int PTE_W     = PPN_W + PERM_W + 1;
    localparam int LVL_W     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [VPN_W-1:0]  vpn_i = '0;
    logic [PPN_W-1:0]  ptbr_i = '0;
    logic              busy_o, mem_req_o, done_o, fault_o;
    logic [PA_W-1:0]   mem_addr_o;
    logic              mem_gnt_i = 1'b0;
    logic              mem_rvalid_i = 1'b0;
    logic [PTE_W-1:0]  mem_rdata_i = '0;
    logic [LVL_W-1:0]  fault_lvl_o;
    logic [PPN_W-1:0]  res_ppn_o;
    logic [PERM_W-1:0] res_perm_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ptw_walker #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .PG_SH(PG_SH),
                 .PERM_W(PERM_W), .PTE_BYTES(PTE_BYTES)) i_ptw_walker (
        .clk, .rst_n, .start_i, .vpn_i, .ptbr_i, .busy_o, .mem_req_o, .mem_addr_o,
        .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i, .done_o, .fault_o, .fault_lvl_o,
        .res_ppn_o, .res_perm_o
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [IDX_W-1:0] field_of(input logic [VPN_W-1:0] v, input int l);
        return IDX_W'(v >> ((LEVELS - 1 - l) * IDX_W));
    endfunction

    function automatic logic [PA_W-1:0] entry_addr(input logic [PPN_W-1:0] b, input logic [IDX_W-1:0] i);
        return (PA_W'(b) << PG_SH) + PA_W'(i) * PA_W'(PTE_BYTES);
    endfunction

    // flt_lvl < 0: every entry present
    task automatic do_walk(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ptbr,
                           input int flt_lvl, input bit poke, input int max_dly);
        logic [PPN_W-1:0]  base;
        logic [PPN_W-1:0]  frm;
        logic [PERM_W-1:0] prm;
        base = ptbr;
        @(negedge clk);
        start_i = 1'b1; vpn_i = vpn; ptbr_i = ptbr;
        @(negedge clk);
        start_i = 1'b0; vpn_i = ~vpn; ptbr_i = ~ptbr;
        chk("R9 busy after start", 32'(busy_o), 32'd1);
        for (int l = 0; l < LEVELS; l++) begin
            int stall = $urandom_range(max_dly, 0);
            int dly = $urandom_range(max_dly, 0);
            for (int s = 0; s <= stall; s++) begin
                chk("R4 request held", 32'(mem_req_o), 32'd1);
                if (l == 0) chk("R2 first address", 32'(mem_addr_o), 32'(entry_addr(base, field_of(vpn, l))));
                else        chk("R3 level address", 32'(mem_addr_o), 32'(entry_addr(base, field_of(vpn, l))));
                if (s == stall) mem_gnt_i = 1'b1;
                @(negedge clk);
            end
            mem_gnt_i = 1'b0;
            if (poke && l == 0) begin
                start_i = 1'b1; vpn_i = VPN_W'($urandom); ptbr_i = PPN_W'($urandom);
                @(negedge clk);
                start_i = 1'b0;
                chk("R9 start ignored", 32'(busy_o), 32'd1);
            end
            for (int d = 0; d < dly; d++) begin
                chk("R4 no request while waiting", 32'(mem_req_o), 32'd0);
                @(negedge clk);
            end
            frm = PPN_W'($urandom);
            prm = PERM_W'($urandom);
            mem_rdata_i = {frm, prm, (l == flt_lvl) ? 1'b0 : 1'b1};
            mem_rvalid_i = 1'b1;
            @(negedge clk);
            mem_rvalid_i = 1'b0;
            mem_rdata_i = PTE_W'($urandom);
            if (l == flt_lvl) begin
                chk("R7 fault", 32'(fault_o), 32'd1);
                chk("R7 fault level", 32'(fault_lvl_o), 32'(l));
                chk("R8 no done with fault", 32'(done_o), 32'd0);
                chk("R8 idle at fault", 32'(busy_o), 32'd0);
                @(negedge clk);
                chk("R8 fault one cycle", 32'(fault_o), 32'd0);
                chk("R7 no read after fault", 32'(mem_req_o), 32'd0);
                return;
            end else if (l == LEVELS - 1) begin
                chk("R6 done", 32'(done_o), 32'd1);
                chk("R6 ppn", 32'(res_ppn_o), 32'(frm));
                chk("R6 perm", 32'(res_perm_o), 32'(prm));
                chk("R8 idle at done", 32'(busy_o), 32'd0);
                chk("R8 no fault with done", 32'(fault_o), 32'd0);
                @(negedge clk);
                chk("R8 done one cycle", 32'(done_o), 32'd0);
                chk("R6 no extra read", 32'(mem_req_o), 32'd0);
            end else begin
                chk("R5 present continues", 32'(done_o | fault_o), 32'd0);
                base = frm;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 busy reset", 32'(busy_o), 32'd0);
        chk("R1 req reset", 32'(mem_req_o), 32'd0);
        chk("R1 done reset", 32'(done_o | fault_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        do_walk('0, '0, -1, 1'b0, 0);
        do_walk('1, '1, -1, 1'b0, 3);
        do_walk(12'h5a3, 8'h21, 0, 1'b0, 2);
        do_walk(12'h3c7, 8'h80, LEVELS - 1, 1'b0, 2);
        do_walk(12'h9e1, 8'h44, 1, 1'b1, 1);
        do_walk(12'h123, 8'h7f, -1, 1'b1, 4);
        // random walks
        for (int n = 0; n < 60; n++) begin
            int f = ($urandom_range(3, 0) == 0) ? int'($urandom_range(LEVELS - 1, 0)) : -1;
            do_walk(VPN_W'($urandom), PPN_W'($urandom), f, 1'($urandom), 4);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule